// File: doc/BRIEF.md
# Oversampling Majority-Vote Serial Receiver

This block receives asynchronous serial characters on a single line. It advances only on a sub-bit enable pulse (`tick`) that an outside divider raises eight times per bit period. The line is first resynchronised through a two-flop chain. While idle, the receiver hunts for a start bit and accepts one only after four consecutive low samples. From then on it runs a phase counter. Each later bit is decided by a two-of-three vote over the samples taken in sub-bit periods 4, 5 and 6 of that bit.

The frame format is set by static configuration pins:
- 1 to 8 data bits, least significant first;
- an optional address flag bit;
- optional even or odd parity;
- one or two stop bits.

The configuration is captured when a start bit is accepted. At the end of each frame the block presents the data, the address flag, a parity error and a framing error, together with a single-cycle `rx_valid` strobe.

A serial line cannot be stalled, so the output has no ready input and exerts no back-pressure. The consumer must take the result in the cycle `rx_valid` is high. The result registers then hold their values until the next strobe.

Top module: `maj_serial_rx`

## Requirements
- R1: Receive timing advances only in cycles with `tick` high, and every bit after the start bit lasts exactly eight ticks; cycles without `tick` have no effect, whatever the line does.
- R2: A start bit is accepted only when the synchronised line is sampled low on four consecutive ticks. The remaining four ticks of the start bit are not examined.
- R3: A high sample among those four start samples abandons the attempt, and the hunt for a start bit restarts from zero at the next low sample.
- R4: Each bit after the start bit takes the value held by at least two of the samples in its 4th, 5th and 6th tick. Samples in its 1st to 3rd, 7th and 8th tick have no effect.
- R5: Data bits arrive least significant first into `rx_data[0]` upward. Their count is `cfg_data_bits` for values 1 to 8; the value 0 or a value above 8 selects 8. Unused upper bits of `rx_data` read 0.
- R6: With `cfg_addr_en` high, one bit directly after the data bits is reported on `rx_addr`. With it low, no such bit is received and `rx_addr` reads 0.
- R7: With `cfg_parity_en` high, a parity bit follows the data and address bits. `rx_parity_err` is 1 when the count of ones over data, address and parity bits is odd (`cfg_parity_odd`=0) or even (`cfg_parity_odd`=1). With parity disabled, `rx_parity_err` is 0.
- R8: One stop bit, or two with `cfg_two_stop` high, end the frame. A stop bit resolved as 0 sets `rx_frame_err`, ends the frame at that bit (a second stop bit is not awaited), and returns the block to the start hunt.
- R9: `rx_valid` is high for exactly one cycle per frame: the tick cycle that ends the final stop bit, or the failing stop bit. After reset all outputs are 0.
- R10: Configuration pins are captured when a start bit is accepted; changes during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sub-bit enable, eight per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_data_bits | input | 4 | Data bit count (1..8, 0 or >8 means 8) |
| cfg_addr_en | input | 1 | Expect an address flag bit after data |
| cfg_parity_en | input | 1 | Expect a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rx_valid | output | 1 | One-cycle strobe: result fields are new |
| rx_data | output | 8 | Received data, LSB aligned |
| rx_addr | output | 1 | Received address flag bit |
| rx_parity_err | output | 1 | Parity mismatch on this frame |
| rx_frame_err | output | 1 | A stop bit was received as 0 |

## Verification
The hardest situation to reach is a line that disagrees with itself inside one bit. The two cases are a lone minority sample among periods 4 to 6, and disturbances confined to the periods outside the voting window. Both must leave the result untouched. Clean stimulus never produces either.

The bench therefore drives the line one tick at a time and applies random per-bit glitch masks that flip only those periods. A directed frame flips two of the three vote samples, so the bit is inverted. Further directed cases cover:
- false starts of one to three low ticks, followed directly by a real frame;
- a failing first stop bit among two;
- configuration changed in mid-frame.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    F_DATA = 2'd0,
    F_ADDR = 2'd1,
    F_PAR  = 2'd2,
    F_STOP = 2'd3
  } rx_field_e;

  typedef struct packed {
    logic addr_en;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_flags_t;

endpackage

// File: rtl/rxm_sync.sv
module rxm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= 1'b1;
        end else begin
          chain_q[s] <= (s == 0) ? d : chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rxm_vote.sv
module rxm_vote #(
  parameter int OVS   = 8,
  parameter int FIRST = 4,
  parameter int NVOTE = 3,
  localparam int PH_W = $clog2(OVS),
  localparam int CW   = $clog2(NVOTE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            sin,
  output logic            bit_o
);

  logic [NVOTE-1:0] samp_q;
  logic [CW-1:0]    ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
    end else if (tick) begin
      for (int g = 0; g < NVOTE; g++) begin
        if (phase == PH_W'(FIRST - 1 + g)) samp_q[g] <= sin;
      end
    end
  end

  always_comb begin
    ones = '0;
    for (int g = 0; g < NVOTE; g++) ones = ones + CW'(samp_q[g]);
  end

  assign bit_o = (ones > CW'(NVOTE / 2));

  AST_SAMPLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(samp_q)); // R4

endmodule

// File: rtl/rxm_fieldmap.sv
module rxm_fieldmap
  import rxm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NB_W   = 4,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [NB_W-1:0]  nbits,
  input  rx_flags_t        flags,
  output rx_field_e        field,
  output logic             last
);

  localparam int XW = IDX_W + 1;

  logic [XW-1:0] n_eff, a_end, p_end, total, ix;

  always_comb begin
    if (nbits == '0 || nbits > NB_W'(DATA_W)) n_eff = XW'(DATA_W);
    else                                      n_eff = XW'(nbits);
    a_end = n_eff + XW'(flags.addr_en);
    p_end = a_end + XW'(flags.par_en);
    total = p_end + XW'(1) + XW'(flags.two_stop);
    ix    = XW'(idx);
    if (ix < n_eff)      field = F_DATA;
    else if (ix < a_end) field = F_ADDR;
    else if (ix < p_end) field = F_PAR;
    else                 field = F_STOP;
    last = (ix == total - XW'(1));
  end

endmodule

// File: rtl/maj_serial_rx.sv
module maj_serial_rx
  import rxm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OVS       = 8,
  parameter int START_RUN = 4,
  parameter int VOTE_AT   = 4,
  parameter int SYNC_N    = 2,
  localparam int NB_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [NB_W-1:0]   cfg_data_bits,
  input  logic              cfg_addr_en,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_parity_err,
  output logic              rx_frame_err
);

  localparam int PH_W  = $clog2(OVS);
  localparam int CNT_W = (START_RUN > 1) ? $clog2(START_RUN) : 1;
  localparam int IDX_W = $clog2(DATA_W + 5);
  localparam int DIX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  PH_RESUME = PH_W'(START_RUN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(START_RUN - 1);

  rx_state_e          st;
  logic [CNT_W-1:0]   lowcnt;
  logic [PH_W-1:0]    ph;
  logic [IDX_W-1:0]   idx;
  logic [NB_W-1:0]    nbits_q;
  rx_flags_t          flags_q;
  logic [DATA_W-1:0]  data_q;
  logic               addr_q;
  logic               parx_q;
  logic               sin_s;
  logic               bit_v;
  rx_field_e          fld;
  logic               fld_last;

  rxm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (sin_s)
  );

  rxm_vote #(.OVS(OVS), .FIRST(VOTE_AT), .NVOTE(3)) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .phase (ph),
    .sin   (sin_s),
    .bit_o (bit_v)
  );

  rxm_fieldmap #(.DATA_W(DATA_W), .NB_W(NB_W), .IDX_W(IDX_W)) u_map (
    .idx   (idx),
    .nbits (nbits_q),
    .flags (flags_q),
    .field (fld),
    .last  (fld_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_HUNT;
      lowcnt        <= '0;
      ph            <= '0;
      idx           <= '0;
      nbits_q       <= '0;
      flags_q       <= '0;
      data_q        <= '0;
      addr_q        <= 1'b0;
      parx_q        <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_addr       <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (st)
          ST_HUNT: begin
            if (sin_s) begin
              lowcnt <= '0;
            end else if (lowcnt == RUN_LAST) begin
              st      <= ST_START;
              lowcnt  <= '0;
              ph      <= PH_RESUME;
              nbits_q <= cfg_data_bits;
              flags_q <= '{addr_en: cfg_addr_en, par_en: cfg_parity_en,
                           par_odd: cfg_parity_odd, two_stop: cfg_two_stop};
              data_q  <= '0;
              addr_q  <= 1'b0;
              parx_q  <= 1'b0;
            end else begin
              lowcnt <= lowcnt + 1'b1;
            end
          end
          ST_START: begin
            if (ph == PH_LAST) begin
              st  <= ST_BITS;
              ph  <= '0;
              idx <= '0;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_BITS: begin
            if (ph != PH_LAST) begin
              ph <= ph + 1'b1;
            end else begin
              ph  <= '0;
              idx <= idx + 1'b1;
              case (fld)
                F_DATA: begin
                  data_q[idx[DIX_W-1:0]] <= bit_v;
                  parx_q <= parx_q ^ bit_v;
                end
                F_ADDR: begin
                  addr_q <= bit_v;
                  parx_q <= parx_q ^ bit_v;
                end
                F_PAR: parx_q <= parx_q ^ bit_v;
                default: begin
                  if (!bit_v || fld_last) begin
                    st            <= ST_HUNT;
                    rx_valid      <= 1'b1;
                    rx_data       <= data_q;
                    rx_addr       <= addr_q;
                    rx_parity_err <= flags_q.par_en & (parx_q ^ flags_q.par_odd);
                    rx_frame_err  <= ~bit_v;
                  end
                end
              endcase
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  AST_START_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st) == ST_HUNT) |->
      ($past(tick) && !$past(sin_s) && $past(lowcnt) == RUN_LAST)); // R2

  AST_HUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && tick && sin_s) |=> (st == ST_HUNT && lowcnt == '0)); // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9

  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(tick) && $past(st) == ST_BITS && st == ST_HUNT)); // R8

  AST_NO_PERR_WO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !flags_q.par_en) |-> !rx_parity_err); // R7

  AST_NO_ADDR_WO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !flags_q.addr_en) |-> !rx_addr); // R6

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st) && $stable(ph) && $stable(lowcnt))); // R1

endmodule

// File: tb/test_maj_serial_rx.sv
module test_maj_serial_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [3:0] c_nb = 4'd8;
  logic       c_addr = 1'b0, c_par = 1'b0, c_odd = 1'b0, c_two = 1'b0;
  logic       rx_valid, rx_addr, rx_parity_err, rx_frame_err;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  int cyc = 0;
  logic [7:0] bit0_mask = 8'h00;

  maj_serial_rx i_maj_serial_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_data_bits(c_nb), .cfg_addr_en(c_addr), .cfg_parity_en(c_par),
    .cfg_parity_odd(c_odd), .cfg_two_stop(c_two),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr(rx_addr),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rx_valid) pulses <= pulses + 1;
    if (cyc == 190000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sub-bit period: line level set three clocks before the tick edge
  task automatic do_tick(input logic v);
    rxd = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [7:0] mask);
    for (int k = 0; k < 8; k++) do_tick(v ^ mask[k]);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) do_tick(1'b1);
  endtask

  function automatic logic [7:0] gmask();
    int r;
    r = $urandom % 4;
    if (r == 1) return 8'h01 << (3 + ($urandom % 3));
    if (r == 2) return 8'($urandom) & 8'hC7;
    return 8'h00;
  endfunction

  function automatic logic vote_of(input logic v, input logic [7:0] mask);
    int c;
    c = 0;
    for (int k = 3; k < 6; k++) c += int'(v ^ mask[k]);
    return (c >= 2);
  endfunction

  function automatic int eff_bits(input logic [3:0] nb);
    return (nb == 0 || nb > 8) ? 8 : int'(nb);
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic a, input logic bad_par,
                           input int bad_stop, input logic glitch, input logic scramble);
    int n, ns, p0;
    logic [7:0] dm, ex_d;
    logic sa, sp, so, st2, ptrue, psent, sb, ex_perr;
    logic [3:0] snb;
    n = eff_bits(c_nb);
    snb = c_nb; sa = c_addr; sp = c_par; so = c_odd; st2 = c_two;
    ns = st2 ? 2 : 1;
    dm = 8'h00;
    for (int i = 0; i < n; i++) dm[i] = d[i];
    ex_d = dm;
    if (bit0_mask != 0) ex_d[0] = vote_of(dm[0], bit0_mask);
    ptrue = (^dm) ^ (sa & a) ^ so;
    psent = ptrue ^ bad_par;
    ex_perr = sp & ((^ex_d) ^ (sa & a) ^ psent ^ so);
    p0 = pulses;
    send_bit(1'b0, glitch ? (gmask() & 8'hF0) : 8'h00);
    if (scramble) begin
      c_nb = 4'($urandom); c_addr = ~sa; c_par = ~sp; c_odd = ~so; c_two = ~st2;
    end
    for (int i = 0; i < n; i++)
      send_bit(dm[i], (i == 0 && bit0_mask != 0) ? bit0_mask : (glitch ? gmask() : 8'h00));
    if (sa) send_bit(a, glitch ? gmask() : 8'h00);
    if (sp) send_bit(psent, glitch ? gmask() : 8'h00);
    for (int s = 1; s <= ns; s++) begin
      sb = (bad_stop == s) ? 1'b0 : 1'b1;
      send_bit(sb, 8'h00);
      if (!sb || s == ns) begin
        chk("R9 valid at frame end", rx_valid, 1);
        chk("R5 data", rx_data, ex_d);
        chk("R6 address flag", rx_addr, sa & a);
        chk("R7 parity error", rx_parity_err, ex_perr);
        chk("R8 framing error", rx_frame_err, !sb);
        @(negedge clk);
        chk("R9 one-cycle strobe", rx_valid, 0);
        chk("R9 one strobe per frame", pulses - p0, 1);
        break;
      end
    end
    c_nb = snb; c_addr = sa; c_par = sp; c_odd = so; c_two = st2;
    rxd = 1'b1;
  endtask

  initial begin
    int p0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", rx_valid, 0);
    chk("R9 reset data", rx_data, 0);
    chk("R9 reset flags", {rx_addr, rx_parity_err, rx_frame_err}, 0);
    rst_n = 1'b1;
    idle(4);

    // R5 basic 8 data bits, 1 stop
    run_frame(8'hA5, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);

    // R6 R7 five data bits, address, even parity
    c_nb = 4'd5; c_addr = 1'b1; c_par = 1'b1; c_odd = 1'b0;
    run_frame(8'h16, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    idle(2);
    // R7 odd parity, corrupted parity bit
    c_odd = 1'b1;
    run_frame(8'h0B, 1'b0, 1'b1, 0, 1'b0, 1'b0);
    idle(2);

    // R8 two stops, first fails, then second fails
    c_nb = 4'd8; c_addr = 1'b0; c_par = 1'b0; c_two = 1'b1;
    run_frame(8'h3C, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    idle(3);
    run_frame(8'hC3, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    idle(3);
    c_two = 1'b0;

    // R3 false starts of 3 and 1 low ticks
    p0 = pulses;
    for (int i = 0; i < 3; i++) do_tick(1'b0);
    do_tick(1'b1);
    do_tick(1'b0);
    idle(10);
    chk("R3 false start yields no strobe", pulses - p0, 0);
    for (int i = 0; i < 3; i++) do_tick(1'b0);
    do_tick(1'b1);
    run_frame(8'h5A, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);

    // R4 two vote samples flipped inverts the bit; one flipped does not
    bit0_mask = 8'h18;
    run_frame(8'h80, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);
    bit0_mask = 8'hE7;
    run_frame(8'h81, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);
    bit0_mask = 8'h20;
    run_frame(8'h01, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);
    bit0_mask = 8'h00;

    // R5 count 0 and 12 select 8 bits
    c_nb = 4'd0;
    run_frame(8'hF1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);
    c_nb = 4'd12;
    run_frame(8'h9E, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);

    // R10 configuration scrambled after start
    c_nb = 4'd6; c_par = 1'b1;
    run_frame(8'h2D, 1'b0, 1'b0, 0, 1'b0, 1'b1);
    idle(2);
    c_nb = 4'd8; c_par = 1'b0;

    // R1 line low without ticks has no effect
    p0 = pulses;
    rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 no strobe without ticks", pulses - p0, 0);
    run_frame(8'h69, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    idle(2);

    // random frames with glitches, corruption and all formats
    for (int it = 0; it < 120; it++) begin
      c_nb = 4'(1 + ($urandom % 8));
      c_addr = 1'($urandom); c_par = 1'($urandom);
      c_odd = 1'($urandom); c_two = 1'($urandom);
      run_frame(8'($urandom), 1'($urandom), ($urandom % 4) == 0,
                (($urandom % 5) == 0) ? int'(1 + $urandom % 2) : 0,
                1'($urandom), ($urandom % 8) == 0);
      idle(1 + int'($urandom % 6));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule